// File: doc/BRIEF.md
# Split-Phase Dual-Access Data RAM

This block is a 544-word by 16-bit on-chip RAM that serves one write and one read in the same machine cycle. A processor pipeline drives a write port (enable, address space, address, data) and a read port (enable, address space, address). The write is treated as happening in the first half of the cycle and the read in the second half. A load that hits the location stored in the same cycle therefore returns the new value, with no extra cycle.

The storage is split into three banks. Bank 0 holds 256 words and bank 1 holds 256 words. Bank 2 is a 32-word scratch bank. Banks 1 and 2 always decode in data space. A single mapping input places bank 0 either at a data-space window or at a program-space window, so bank 0 can hold code. The mapping input is registered, and a change to it acts on accesses from the next cycle onward. Changing the mapping never alters stored words.

Read results are registered. A read presented in cycle N shows its data and miss flag on the outputs after the clock edge that ends cycle N.

Top module: `dual_access_ram`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rd_data` is 0 and `rd_miss` is 0.
- R2: A word written to a mapped location can be read back unchanged. The read result appears one clock edge after the read is presented.
- R3: When a write and a read in the same cycle target the same location, the read returns the data being written in that cycle.
- R4: With the mapping bit at 0, bank 0 occupies data addresses 0x0200 to 0x02FF, and every program-space access (`*_space`=1) misses.
- R5: With the mapping bit at 1, bank 0 occupies program addresses 0xFE00 to 0xFEFF, and data addresses 0x0200 to 0x02FF miss.
- R6: Bank 1 always occupies data addresses 0x0300 to 0x03FF, and bank 2 always occupies data addresses 0x0060 to 0x007F, whatever the mapping bit is.
- R7: A read of an address that decodes to no bank sets `rd_miss` to 1 and returns 0. A write to such an address changes no stored word.
- R8: A change of `map_prog` applies from the next cycle. An access in the cycle where `map_prog` changes still decodes with the previous mapping.
- R9: Toggling the mapping bit leaves the contents of every bank unchanged.
- R10: A cycle with `rd_en` low leaves `rd_data` unchanged and drives `rd_miss` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_prog | input | 1 | Bank 0 mapping: 0 places it in data space, 1 in program space |
| wr_en | input | 1 | Write request this cycle |
| wr_space | input | 1 | Write address space: 0 data, 1 program |
| wr_addr | input | 16 | Write word address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read request this cycle |
| rd_space | input | 1 | Read address space: 0 data, 1 program |
| rd_addr | input | 16 | Read word address |
| rd_data | output | 16 | Registered read data |
| rd_miss | output | 1 | Registered flag: the last read decoded to no bank |

## Verification
The assertions check four rules on every cycle:
- A miss always carries zero data.
- An idle read port holds its data.
- A same-address write and read yields the write data, unless the read missed.
- The bank 0 window that the previous cycle's mapping excludes always misses.

Only the bench scenarios can show that stored words survive mapping toggles and ignored writes. The same holds for the exact bank boundaries, and for the rule that the cycle in which the mapping changes still uses the old map. The bench shows these by running a reference image of all 544 words against random and directed traffic.

// File: rtl/dual_access_ram.sv
module dual_access_ram #(
  parameter int DW           = 16,
  parameter int AW           = 16,
  parameter int B0_WORDS     = 256,
  parameter int B1_WORDS     = 256,
  parameter int B2_WORDS     = 32,
  parameter int B0_DATA_BASE = 'h0200,
  parameter int B0_PROG_BASE = 'hFE00,
  parameter int B1_BASE      = 'h0300,
  parameter int B2_BASE      = 'h0060
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          map_prog,
  input  logic          wr_en,
  input  logic          wr_space,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_space,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_miss
);
  localparam int DEPTH  = B0_WORDS + B1_WORDS + B2_WORDS;
  localparam int IW     = $clog2(DEPTH);
  localparam int B1_OFF = B0_WORDS;
  localparam int B2_OFF = B0_WORDS + B1_WORDS;

  logic          map_q;
  logic [DW-1:0] mem [DEPTH];
  logic          wr_hit, rd_hit, same_loc;
  logic [IW-1:0] wr_idx, rd_idx;

  function automatic logic [IW:0] locate(input logic space, input logic [AW-1:0] a,
                                         input logic pmap);
    int ai, b0;
    ai = int'(a);
    b0 = pmap ? B0_PROG_BASE : B0_DATA_BASE;
    if (space == pmap && ai >= b0 && ai < b0 + B0_WORDS)
      return {1'b1, IW'(ai - b0)};
    if (!space && ai >= B1_BASE && ai < B1_BASE + B1_WORDS)
      return {1'b1, IW'(ai - B1_BASE + B1_OFF)};
    if (!space && ai >= B2_BASE && ai < B2_BASE + B2_WORDS)
      return {1'b1, IW'(ai - B2_BASE + B2_OFF)};
    return '0;
  endfunction

  assign {wr_hit, wr_idx} = locate(wr_space, wr_addr, map_q);
  assign {rd_hit, rd_idx} = locate(rd_space, rd_addr, map_q);
  assign same_loc = wr_en && wr_hit && (wr_idx == rd_idx);

  always_ff @(posedge clk) begin
    if (rst_n && wr_en && wr_hit)
      mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q   <= 1'b0;
      rd_data <= '0;
      rd_miss <= 1'b0;
    end else begin
      map_q   <= map_prog;
      rd_miss <= rd_en && !rd_hit;
      if (rd_en)
        rd_data <= !rd_hit ? '0 : (same_loc ? wr_data : mem[rd_idx]);
    end
  end
endmodule

module dual_access_ram_chk #(
  parameter int DW           = 16,
  parameter int AW           = 16,
  parameter int B0_WORDS     = 256,
  parameter int B0_DATA_BASE = 'h0200
) (
  input logic          clk,
  input logic          rst_n,
  input logic          map_prog,
  input logic          wr_en,
  input logic          wr_space,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic          rd_space,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          rd_miss
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0; else seen <= 1'b1;

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |-> rd_data == '0); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !rd_en) |=> (!rd_miss && $stable(rd_data))); // R10

  AST_SAME_CYCLE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && rd_space == wr_space && rd_addr == wr_addr)
      |=> (rd_miss || rd_data == $past(wr_data))); // R3

  AST_PROG_MISS_MAP0: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && rd_en && rd_space && !$past(map_prog)) |=> rd_miss); // R4

  AST_DATA_B0_MISS_MAP1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && rd_en && !rd_space && $past(map_prog) &&
     int'(rd_addr) >= B0_DATA_BASE && int'(rd_addr) < B0_DATA_BASE + B0_WORDS)
      |=> rd_miss); // R5
endmodule

bind dual_access_ram dual_access_ram_chk #(
  .DW(DW), .AW(AW), .B0_WORDS(B0_WORDS), .B0_DATA_BASE(B0_DATA_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .map_prog(map_prog),
  .wr_en(wr_en), .wr_space(wr_space), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_space(rd_space), .rd_addr(rd_addr),
  .rd_data(rd_data), .rd_miss(rd_miss)
);

// File: tb/dual_access_ram_tb_top.sv
`timescale 1ns/1ps
module dual_access_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_prog = 1'b0;
  logic        wr_en = 1'b0, wr_space = 1'b0, rd_en = 1'b0, rd_space = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_miss;

  int checks = 0, failures = 0;
  logic [15:0] img [544];
  logic        map_m = 1'b0;
  logic [15:0] last_m = '0;

  always #2 clk = ~clk;

  dual_access_ram dut_i (
    .clk(clk), .rst_n(rst_n), .map_prog(map_prog),
    .wr_en(wr_en), .wr_space(wr_space), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_space(rd_space), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_miss(rd_miss)
  );

  function automatic int where(input logic sp, input logic [15:0] a, input logic pm);
    int v = int'(a);
    if (!sp && !pm && v >= 'h0200 && v <= 'h02FF) return v - 'h0200;
    if (sp && pm && v >= 'hFE00 && v <= 'hFEFF) return v - 'hFE00;
    if (!sp && v >= 'h0300 && v <= 'h03FF) return 256 + v - 'h0300;
    if (!sp && v >= 'h0060 && v <= 'h007F) return 512 + v - 'h0060;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [15:0] ed, input logic em);
    checks++;
    if (rd_data !== ed || rd_miss !== em) begin
      failures++;
      $display("FAIL %s: rd_data=%h rd_miss=%b expected rd_data=%h rd_miss=%b",
               tag, rd_data, rd_miss, ed, em);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic ws, input logic [15:0] wa,
                      input logic [15:0] wd, input logic re, input logic rs,
                      input logic [15:0] ra, input logic mp, input bit chk);
    int wi, ri;
    logic [15:0] ed;
    logic em;
    wr_en = we; wr_space = ws; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_space = rs; rd_addr = ra; map_prog = mp;
    wi = where(ws, wa, map_m);
    ri = where(rs, ra, map_m);
    em = 1'b0;
    ed = last_m;
    if (re) begin
      if (ri < 0) begin em = 1'b1; ed = '0; end
      else if (we && wi == ri) ed = wd;
      else ed = img[ri];
    end
    @(posedge clk);
    if (we && wi >= 0) img[wi] = wd;
    map_m = mp;
    last_m = ed;
    @(negedge clk);
    if (chk) check(tag, ed, em);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", 16'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 16'h0, 1'b0);

    for (int i = 0; i < 256; i++) step("R2", 1, 0, 16'(16'h0200 + i), 16'(i * 7 + 3), 0, 0, 0, 0, 0);
    for (int i = 0; i < 256; i++) step("R2", 1, 0, 16'(16'h0300 + i), 16'(16'hA000 ^ i), 0, 0, 0, 0, 0);
    for (int i = 0; i < 32; i++)  step("R2", 1, 0, 16'(16'h0060 + i), 16'(16'h5500 + i), 0, 0, 0, 0, 0);

    step("R2", 0, 0, 0, 0, 1, 0, 16'h0205, 0, 1);
    step("R6", 0, 0, 0, 0, 1, 0, 16'h03FF, 0, 1);
    step("R6", 0, 0, 0, 0, 1, 0, 16'h007F, 0, 1);
    step("R4", 0, 0, 0, 0, 1, 1, 16'hFE05, 0, 1);
    step("R3", 1, 0, 16'h0310, 16'hBEEF, 1, 0, 16'h0310, 0, 1);
    step("R10", 0, 0, 0, 0, 0, 0, 16'h0310, 0, 1);
    step("R7", 1, 0, 16'h0400, 16'h1234, 1, 0, 16'h0400, 0, 1);
    step("R7", 0, 0, 0, 0, 1, 0, 16'h0080, 0, 1);
    step("R7", 0, 0, 0, 0, 1, 0, 16'h01FF, 0, 1);
    step("R8", 0, 0, 0, 0, 1, 0, 16'h0205, 1, 1);
    step("R5", 0, 0, 0, 0, 1, 0, 16'h0205, 1, 1);
    step("R5", 0, 0, 0, 0, 1, 1, 16'hFE05, 1, 1);
    step("R6", 0, 0, 0, 0, 1, 0, 16'h0300, 1, 1);
    step("R7", 1, 0, 16'h0205, 16'hDEAD, 0, 0, 0, 1, 0);
    step("R8", 0, 0, 0, 0, 1, 1, 16'hFEFF, 0, 1);
    step("R9", 0, 0, 0, 0, 1, 0, 16'h0205, 0, 1);
    step("R9", 0, 0, 0, 0, 1, 0, 16'h02FF, 0, 1);

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a [2];
      logic sp [2];
      for (int k = 0; k < 2; k++) begin
        case ($urandom % 6)
          0: begin sp[k] = 0; a[k] = 16'(16'h0200 + $urandom % 256); end
          1: begin sp[k] = 1; a[k] = 16'(16'hFE00 + $urandom % 256); end
          2: begin sp[k] = 0; a[k] = 16'(16'h0300 + $urandom % 256); end
          3: begin sp[k] = 0; a[k] = 16'(16'h0060 + $urandom % 32); end
          4: begin sp[k] = 1'($urandom); a[k] = 16'($urandom); end
          default: begin sp[k] = 0; a[k] = 16'(16'h0080 + $urandom % 16); end
        endcase
      end
      if ($urandom % 4 == 0) begin sp[1] = sp[0]; a[1] = a[0]; end
      step("R2", 1'($urandom), sp[0], a[0], 16'($urandom), ($urandom % 5) != 0, sp[1], a[1],
           ($urandom % 16 == 0) ? ~map_m : map_m, 1);
    end

    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 256; i++) step("R9", 0, 0, 0, 0, 1, 0, 16'(16'h0300 + i), 0, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule